// File: doc/BRIEF.md
# Clocked Synchronous Serial Byte Port

This block moves one byte at a time over a three-wire synchronous serial link: a clock pin that can either drive or receive the data clock, a serial data output and a serial data input. Software sets up the block through two byte-wide registers on a simple CPU register bus: a control/status register and a data register that is shared by the transmit and receive directions.

A 3-bit speed code picks the data clock. Seven codes divide the system clock by 20, 40, 80, 160, 320, 640 or 1280, and the block drives the clock pin. The eighth code makes the clock pin an input, so another device supplies the data clock. Software starts one transfer by setting either the transmit or the receive enable. Exactly eight bits then move, least significant first. When the last bit is done the enable clears itself, a completion flag rises, and an interrupt request is raised if the interrupt enable is set. Any read or write of the data register clears the completion flag.

Top module: `clkser_unit`

## Requirements
- R1: After reset the control register reads 0x07, `irq` is 0, `sclk_oe` is 0, and both `sclk_out` and `sdo` are 1.
- R2: For speed code c in 0..6 the data clock period is 20·2^c system cycles. The first falling edge comes half a period after the enabling write, and the completion flag is set 8 full periods (160·2^c cycles) after that write.
- R3: With speed code 7, `sclk_oe` stays 0. The synchronised edges of `sclk_in` clock the transfer in the same way as the internal clock does, and the flag and enable behave as in R7.
- R4: `sclk_oe` is 1 exactly while an internal speed code (0..6) is selected and an enable is set. `sclk_out` rests high whenever no transfer is running.
- R5: During a transmit, `sdo` takes data bit k on the k-th falling data clock edge (k = 0 first, least significant first). A transmit leaves the data register unchanged.
- R6: During a receive, `sdi` is sampled on each rising data clock edge. The first sample becomes bit 0 and the eighth becomes bit 7 of the data register.
- R7: On the eighth rising edge the completion flag (control bit 7) is set, the active enable (bit 5 receive, bit 4 transmit) is cleared, and the clock is left high.
- R8: `irq` is 1 exactly while the completion flag and the interrupt enable (control bit 6) are both 1.
- R9: A read or a write of the data register (address 1) clears the completion flag. A read or a write of the control register (address 0) does not clear it.
- R10: Control bit 7 cannot be written, and bit 3 always reads 0. A control write that sets both bit 5 and bit 4 is ignored in full, so the two enables are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 1 | Register select: 0 control, 1 data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle (clears the flag on a data read) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register |
| irq | output | 1 | Interrupt request |
| sclk_in | input | 1 | Clock pin input value, used with speed code 7 |
| sclk_out | output | 1 | Data clock driven on the clock pin |
| sclk_oe | output | 1 | Clock pin output enable |
| sdo | output | 1 | Serial data output |
| sdi | input | 1 | Serial data input |

## Verification
The assertions check on every cycle that the two enables never meet, that completion sets the flag and drops both enables, that a data register access clears the flag, that the clock idles high once no transfer is running, and that the prescaler count and the output bit move only when they should. Only the bench's scenarios can show the exact divide of each speed code, the least-significant-first bit order on both wires, the externally clocked mode and the read-back of the register fields. The bench sweeps every internal speed code with a transmit, runs receives over several bit patterns, and runs a transmit and a receive clocked from the pin.

// File: rtl/clkser_pkg.sv
package clkser_pkg;
   localparam int SPEED_W = 3;
   localparam logic [SPEED_W-1:0] SPEED_EXT = '1;
   localparam logic ADDR_CTRL = 1'b0;
   localparam logic ADDR_DATA = 1'b1;

   typedef struct packed {
      logic                flag;
      logic                int_en;
      logic                rx_en;
      logic                tx_en;
      logic                rsv;
      logic [SPEED_W-1:0]  speed;
   } ctrl_t;
endpackage

// File: rtl/clkser_prescale.sv
module clkser_prescale #(
   parameter int BASE_DIV = 20,
   parameter int SPEED_W  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run,
   input  logic [SPEED_W-1:0] speed,
   output logic               dclk,
   output logic               fall_ev,
   output logic               rise_ev
);
   localparam int HALF_BASE = BASE_DIV / 2;
   localparam int MAX_HALF  = HALF_BASE << ((1 << SPEED_W) - 2);
   localparam int CNT_W     = $clog2(MAX_HALF) + 1;

   if ((BASE_DIV % 2) != 0 || BASE_DIV < 4) begin : g_bad_div
      $error("clkser_prescale: BASE_DIV must be even and at least 4");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] half_m1;
   logic             tick;

   always_comb begin
      half_m1 = (CNT_W'(HALF_BASE) << speed) - CNT_W'(1);
      tick    = run && (cnt == half_m1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         cnt  <= '0;
         dclk <= 1'b1;
      end else if (tick) begin
         cnt  <= '0;
         dclk <= ~dclk;
      end else begin
         cnt  <= cnt + CNT_W'(1);
      end
   end

   assign fall_ev = tick && dclk;
   assign rise_ev = tick && !dclk;

   // R2: the half-period count never passes its terminal value
   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt <= half_m1));
endmodule

// File: rtl/clkser_edge_sync.sv
module clkser_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic fall_ev,
   output logic rise_ev
);
   if (STAGES < 2) begin : g_bad_stages
      $error("clkser_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES:0] sync;

   for (genvar i = 0; i <= STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) sync[i] <= 1'b1;
            else        sync[i] <= pin;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) sync[i] <= 1'b1;
            else        sync[i] <= sync[i-1];
         end
      end
   end

   assign fall_ev = sync[STAGES]  && !sync[STAGES-1];
   assign rise_ev = !sync[STAGES] && sync[STAGES-1];
endmodule

// File: rtl/clkser_shifter.sv
module clkser_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tx_mode,
   input  logic         rx_mode,
   input  logic         fall_ev,
   input  logic         rise_ev,
   input  logic         sdi,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] shreg,
   output logic         sdo,
   output logic         done
);
   localparam int BC_W = $clog2(W);

   if (W < 2 || (W & (W - 1)) != 0) begin : g_bad_w
      $error("clkser_shifter: W must be a power of two of at least 2");
   end

   logic            run;
   logic [BC_W-1:0] bitcnt;

   assign run  = tx_mode || rx_mode;
   assign done = run && rise_ev && (bitcnt == BC_W'(W - 1));

   always_ff @(posedge clk) begin
      if (!rst_n || !run)  bitcnt <= '0;
      else if (rise_ev)    bitcnt <= bitcnt + BC_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                  sdo <= 1'b1;
      else if (tx_mode && fall_ev) sdo <= shreg[bitcnt];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                  shreg <= '0;
      else if (load)               shreg <= load_val;
      else if (rx_mode && rise_ev) shreg <= {sdi, shreg[W-1:1]};
   end

   // R5: the output bit moves only on a falling data clock edge
   assert_sdo_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !fall_ev |=> $stable(sdo));
   // R5: a transmit never alters the shared data register
   assert_tx_keeps_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_mode && !load) |=> $stable(shreg));
endmodule

// File: rtl/clkser_unit.sv
module clkser_unit
   import clkser_pkg::*;
#(
   parameter int BASE_DIV    = 20,
   parameter int SYNC_STAGES = 2,
   parameter int DATA_W      = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   input  logic              sclk_in,
   output logic              sclk_out,
   output logic              sclk_oe,
   output logic              sdo,
   input  logic              sdi
);
   if (DATA_W != $bits(ctrl_t)) begin : g_bad_width
      $error("clkser_unit: DATA_W must match the control register width");
   end

   logic               flag, int_en, rx_en, tx_en;
   logic [SPEED_W-1:0] speed;
   logic               ext_mode, run;
   logic               i_fall, i_rise, x_fall, x_rise, fall_ev, rise_ev;
   logic               done, data_acc, ctrl_wr_ok;
   logic [DATA_W-1:0]  shreg;
   ctrl_t              wr_view, rd_view;
   logic               unused_wbits;

   assign wr_view      = ctrl_t'(bus_wdata);
   assign unused_wbits = wr_view.flag ^ wr_view.rsv;
   assign ext_mode     = (speed == SPEED_EXT);
   assign run          = rx_en || tx_en;
   assign ctrl_wr_ok   = bus_wr && (bus_addr == ADDR_CTRL) && !(wr_view.rx_en && wr_view.tx_en);
   assign data_acc     = (bus_addr == ADDR_DATA) && (bus_wr || bus_rd);

   clkser_prescale #(.BASE_DIV(BASE_DIV), .SPEED_W(SPEED_W)) u_prescale (
      .clk(clk), .rst_n(rst_n), .run(run && !ext_mode), .speed(speed),
      .dclk(sclk_out), .fall_ev(i_fall), .rise_ev(i_rise));

   clkser_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin(sclk_in),
      .fall_ev(x_fall), .rise_ev(x_rise));

   assign fall_ev = ext_mode ? x_fall : i_fall;
   assign rise_ev = ext_mode ? x_rise : i_rise;

   clkser_shifter #(.W(DATA_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .tx_mode(tx_en), .rx_mode(rx_en),
      .fall_ev(fall_ev), .rise_ev(rise_ev), .sdi(sdi),
      .load(bus_wr && (bus_addr == ADDR_DATA)), .load_val(bus_wdata),
      .shreg(shreg), .sdo(sdo), .done(done));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag   <= 1'b0;
         int_en <= 1'b0;
         rx_en  <= 1'b0;
         tx_en  <= 1'b0;
         speed  <= SPEED_EXT;
      end else begin
         if (ctrl_wr_ok) begin
            int_en <= wr_view.int_en;
            rx_en  <= wr_view.rx_en;
            tx_en  <= wr_view.tx_en;
            speed  <= wr_view.speed;
         end
         if (done) begin
            rx_en <= 1'b0;
            tx_en <= 1'b0;
         end
         if (done)          flag <= 1'b1;
         else if (data_acc) flag <= 1'b0;
      end
   end

   always_comb begin
      rd_view        = '0;
      rd_view.flag   = flag;
      rd_view.int_en = int_en;
      rd_view.rx_en  = rx_en;
      rd_view.tx_en  = tx_en;
      rd_view.speed  = speed;
   end

   assign bus_rdata = (bus_addr == ADDR_DATA) ? shreg : DATA_W'(rd_view);
   assign irq       = flag && int_en;
   assign sclk_oe   = run && !ext_mode;

   // R10: the two enables are never set together
   assert_one_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(rx_en && tx_en));
   // R7: completion raises the flag and drops both enables
   assert_done_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (flag && !rx_en && !tx_en));
   // R9: a data register access clears the flag unless a byte completes
   assert_access_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (data_acc && !done) |=> !flag);
   // R4: the clock rests high once no transfer runs
   assert_idle_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> sclk_out);
endmodule

// File: tb/clkser_unit_bench.sv
module clkser_unit_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       irq, sclk_in = 1'b1, sclk_out, sclk_oe, sdo, sdi = 1'b0;
   int         n_cmp = 0, n_bad = 0;

   always #2 clk = ~clk;

   clkser_unit u_clkser_unit (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
      .sdo(sdo), .sdi(sdi));

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd(1'b0, v);
      chk("R1 ctrl", v, 8'h07);
      chk("R1 irq", irq, 0);
      chk("R1 oe", sclk_oe, 0);
      chk("R1 sclk", sclk_out, 1);
      chk("R1 sdo", sdo, 1);

      // R2/R5: transmit sweep over every internal speed code
      for (int c = 0; c < 7; c++) begin
         logic [7:0] pat;
         int cnt, k;
         logic prev;
         pat = 8'hA5 ^ 8'(c * 59);
         wr(1'b1, pat);
         wr(1'b0, 8'h50 | 8'(c));
         cnt = 1; k = 0; prev = 1'b1;
         while (!irq && cnt < 30000) begin
            if (prev && !sclk_out) begin
               if (k < 8) chk("R5 sdo bit", sdo, pat[k]);
               if (k == 0) chk("R4 oe active", sclk_oe, 1);
               k++;
            end
            prev = sclk_out;
            @(negedge clk);
            cnt++;
         end
         chk("R2 cycles to completion", cnt, (160 << c) + 1);
         chk("R5 falling edges", k, 8);
         chk("R7 clock high", sclk_out, 1);
         chk("R4 oe idle", sclk_oe, 0);
         rd(1'b0, v);
         chk("R7 ctrl after tx", v, 8'hC0 | 8'(c));
         rd(1'b1, v);
         chk("R5 data kept", v, pat);
      end

      // R6/R7: receives at code 0 over several patterns
      for (int p = 0; p < 4; p++) begin
         logic [7:0] pat;
         int k;
         logic prev;
         pat = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : (p == 2) ? 8'h5A : 8'h81;
         wr(1'b1, 8'h3C);
         wr(1'b0, 8'h20);
         k = 0; prev = 1'b1;
         repeat (170) begin
            if (prev && !sclk_out && k < 8) begin
               sdi = pat[k];
               k++;
            end
            prev = sclk_out;
            @(negedge clk);
         end
         chk("R8 irq off with enable 0", irq, 0);
         rd(1'b0, v);
         chk("R7 ctrl after rx", v, 8'h80);
         rd(1'b1, v);
         chk("R6 received byte", v, pat);
         rd(1'b0, v);
         chk("R9 read clears flag", v, 8'h00);
      end

      // R8/R9: interrupt gating and clearing
      wr(1'b0, 8'h20);
      repeat (170) @(negedge clk);
      chk("R8 irq gated", irq, 0);
      wr(1'b0, 8'h40);
      chk("R8 irq raised", irq, 1);
      rd(1'b0, v);
      chk("R9 ctrl read keeps flag", v, 8'hC0);
      wr(1'b1, 8'h00);
      chk("R9 write clears irq", irq, 0);

      // R10: field write rules
      wr(1'b0, 8'hB6);
      rd(1'b0, v);
      chk("R10 both enables ignored", v, 8'h40);
      wr(1'b0, 8'h8D);
      rd(1'b0, v);
      chk("R10 bit7 and bit3", v, 8'h05);
      chk("R4 oe with no enable", sclk_oe, 0);

      // R3: externally clocked transmit
      wr(1'b1, 8'h6B);
      wr(1'b0, 8'h17);
      chk("R3 oe input", sclk_oe, 0);
      for (int k = 0; k < 8; k++) begin
         sclk_in = 1'b0;
         repeat (20) @(negedge clk);
         chk("R3 ext sdo bit", sdo, (8'h6B >> k) & 1);
         sclk_in = 1'b1;
         repeat (20) @(negedge clk);
      end
      rd(1'b0, v);
      chk("R3 ext tx done", v, 8'h87);

      // R3: externally clocked receive
      wr(1'b1, 8'h00);
      wr(1'b0, 8'h27);
      for (int k = 0; k < 8; k++) begin
         sclk_in = 1'b0;
         repeat (10) @(negedge clk);
         sdi = (8'hC6 >> k) & 1;
         repeat (10) @(negedge clk);
         sclk_in = 1'b1;
         repeat (20) @(negedge clk);
      end
      chk("R3 oe stays input", sclk_oe, 0);
      rd(1'b0, v);
      chk("R3 ext rx done", v, 8'h87);
      rd(1'b1, v);
      chk("R3 ext rx byte", v, 8'hC6);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule